// File: doc/BRIEF.md
# Fractional Master Clock Divider

This block derives a master audio clock enable from one of several candidate input clock enables, all of which live in a single clock domain. A phase accumulator advances by a programmable step on every tick of the selected input. It wraps at a programmable modulus, so that the output rate is the input tick rate scaled by (fraction+1)/(divide+1). Each wrap of the accumulator produces a one-cycle output pulse and marks the boundary of an output period.

The ratio can be changed while the divider is running. A write is latched as a pending ratio and a busy flag rises. The pending ratio replaces the active one at the next output-period boundary, and at that moment the accumulator restarts from zero. The flag drops one cycle later. While the flag is high, further ratio writes are ignored. When the output enable is low the divider is idle: its accumulator is held at zero and the output pin simply mirrors a bypass input.

Top module: `frac_mclk_div`

## Requirements
- R1: After reset the update flag is 0, the registered divider pulse is 0, and the active ratio is fraction 0 over divide 0. With the output enabled, every input tick then produces an output pulse.
- R2: The select value k (0 to N_SRC-1) makes `src_en[k]` the only input that advances the accumulator. Cycles without a tick on the selected input produce no output pulse.
- R3: With the output enabled, the accumulator adds fraction+1 on each selected tick. When the sum reaches divide+1, it subtracts divide+1 and `mclk_out` is high for the one cycle after that clock edge. From a zero accumulator, T ticks therefore give floor(T*(fraction+1)/(divide+1)) pulses.
- R4: The accumulator value always stays below the active divide+1.
- R5: While `out_en` is 0, `mclk_out` equals `pad_in` in the same cycle and the accumulator is held at zero. After re-enable, the first pulse follows the ceil((divide+1)/(fraction+1))-th tick.
- R6: A write strobe while the flag is clear, carrying a fraction no greater than the divide value, sets the update flag at the next clock edge.
- R7: Ratio writes made while the update flag is set have no effect.
- R8: A pending ratio becomes active at the clock edge of the next output pulse, or at the next edge if `out_en` is 0. The accumulator restarts at zero on that edge.
- R9: The update flag falls one clock edge after the edge that applies the new ratio. With `out_en` low it is therefore high for exactly two cycles.
- R10: A write whose fraction exceeds its divide value is ignored and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | N_SRC | Candidate input clock enables |
| src_sel | input | SEL_W | Index of the input that drives the divider |
| div_val | input | DIV_W | Divide value written with the strobe |
| frac_val | input | FRAC_W | Fraction value written with the strobe |
| ratio_wr | input | 1 | Ratio write strobe |
| out_en | input | 1 | 1: divider runs and drives the output; 0: bypass |
| pad_in | input | 1 | Bypass input reflected on the output when disabled |
| mclk_out | output | 1 | Divided clock enable, or bypass input |
| upd_busy | output | 1 | Ratio update in progress |

## Verification
The bench builds the block with its defaults: four inputs, a 12-bit divide and an 8-bit fraction. Random ratios are mostly kept below 16, so that thousands of output-period boundaries and many mid-run handovers occur within a short run. Occasional full-scale divide values and fractions above the divide value exercise the wide accumulator and the rejection path. Directed sequences pin down the exact pulse counts, the restart after bypass and the two-cycle flag window.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_WAIT = 2'd1,
        UPD_DONE = 2'd2
    } upd_state_e;
endpackage

// File: rtl/mdiv_src_mux.sv
module mdiv_src_mux #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] src_en,
    input  logic [SEL_W-1:0] src_sel,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_hit
        assign hit[g] = src_en[g] && (src_sel == SEL_W'(g));
    end

    assign tick = |hit;
endmodule

// File: rtl/mdiv_phase_acc.sv
module mdiv_phase_acc #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              restart,
    input  logic [DIV_W-1:0]  act_div,
    input  logic [FRAC_W-1:0] act_frac,
    output logic [DIV_W-1:0]  acc_q,
    output logic              boundary,
    output logic              pulse_q
);
    localparam int SUM_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] acc;
        logic             pulse;
    } acc_t;

    acc_t s_d, s_q;
    logic [SUM_W-1:0] modulus;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] sum;

    always_comb begin
        modulus  = SUM_W'(act_div) + SUM_W'(1);
        step     = SUM_W'(act_frac) + SUM_W'(1);
        sum      = SUM_W'(s_q.acc) + step;
        boundary = run && tick && (sum >= modulus);
        s_d      = s_q;
        s_d.pulse = boundary;
        if (!run) begin
            s_d.acc = '0;
        end else if (boundary) begin
            s_d.acc = restart ? '0 : DIV_W'(sum - modulus);
        end else if (tick) begin
            s_d.acc = DIV_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_q   = s_q.acc;
    assign pulse_q = s_q.pulse;
endmodule

// File: rtl/mdiv_ratio_ctl.sv
module mdiv_ratio_ctl
    import mdiv_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              run,
    input  logic              boundary,
    output logic [DIV_W-1:0]  act_div,
    output logic [FRAC_W-1:0] act_frac,
    output logic [DIV_W-1:0]  pend_div,
    output logic [FRAC_W-1:0] pend_frac,
    output logic              restart,
    output logic              busy
);
    typedef struct packed {
        upd_state_e        st;
        logic [DIV_W-1:0]  adiv;
        logic [FRAC_W-1:0] afrac;
        logic [DIV_W-1:0]  pdiv;
        logic [FRAC_W-1:0] pfrac;
    } ctl_t;

    ctl_t s_d, s_q;
    logic accept;
    logic apply;

    always_comb begin
        accept  = (s_q.st == UPD_IDLE) && wr_stb && (DIV_W'(frac_in) <= div_in);
        apply   = (s_q.st == UPD_WAIT) && (boundary || !run);
        s_d     = s_q;
        unique case (s_q.st)
            UPD_IDLE: if (accept) begin
                s_d.st    = UPD_WAIT;
                s_d.pdiv  = div_in;
                s_d.pfrac = frac_in;
            end
            UPD_WAIT: if (apply) begin
                s_d.st    = UPD_DONE;
                s_d.adiv  = s_q.pdiv;
                s_d.afrac = s_q.pfrac;
            end
            UPD_DONE: s_d.st = UPD_IDLE;
            default:  s_d.st = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: UPD_IDLE, adiv: '0, afrac: '0, pdiv: '0, pfrac: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign act_div   = s_q.adiv;
    assign act_frac  = s_q.afrac;
    assign pend_div  = s_q.pdiv;
    assign pend_frac = s_q.pfrac;
    assign restart   = apply;
    assign busy      = (s_q.st != UPD_IDLE);
endmodule

// File: rtl/frac_mclk_div.sv
module frac_mclk_div #(
    parameter int  N_SRC  = 4,
    parameter int  DIV_W  = 12,
    parameter int  FRAC_W = 8,
    localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              ratio_wr,
    input  logic              out_en,
    input  logic              pad_in,
    output logic              mclk_out,
    output logic              upd_busy
);
    logic              tick;
    logic              boundary;
    logic              restart;
    logic              pulse_q;
    logic [DIV_W-1:0]  acc_q;
    logic [DIV_W-1:0]  act_div;
    logic [FRAC_W-1:0] act_frac;
    logic [DIV_W-1:0]  pend_div;
    logic [FRAC_W-1:0] pend_frac;

    mdiv_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
        .src_en  (src_en),
        .src_sel (src_sel),
        .tick    (tick)
    );

    mdiv_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (out_en),
        .tick     (tick),
        .restart  (restart),
        .act_div  (act_div),
        .act_frac (act_frac),
        .acc_q    (acc_q),
        .boundary (boundary),
        .pulse_q  (pulse_q)
    );

    mdiv_ratio_ctl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (ratio_wr),
        .div_in    (div_val),
        .frac_in   (frac_val),
        .run       (out_en),
        .boundary  (boundary),
        .act_div   (act_div),
        .act_frac  (act_frac),
        .pend_div  (pend_div),
        .pend_frac (pend_frac),
        .restart   (restart),
        .busy      (upd_busy)
    );

    assign mclk_out = out_en ? pulse_q : pad_in;
endmodule

// File: rtl/frac_mclk_div_chk.sv
module frac_mclk_div_chk #(
    parameter int N_SRC  = 4,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              out_en,
    input logic              ratio_wr,
    input logic [DIV_W-1:0]  div_val,
    input logic [FRAC_W-1:0] frac_val,
    input logic              upd_busy,
    input logic              pulse_q,
    input logic [DIV_W-1:0]  acc_q,
    input logic [DIV_W-1:0]  act_div,
    input logic [DIV_W-1:0]  pend_div,
    input logic [FRAC_W-1:0] pend_frac
);
    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= act_div); // R4

    AST_NO_TICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !pulse_q); // R2

    AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (acc_q == '0) && !pulse_q); // R5

    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_busy && ratio_wr && (DIV_W'(frac_val) <= div_val)) |=> upd_busy); // R6

    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy |=> $stable(pend_div) && $stable(pend_frac)); // R7

    AST_BUSY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_busy) |=> upd_busy); // R9

    AST_REJECT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_busy && ratio_wr && (DIV_W'(frac_val) > div_val)) |=> !upd_busy); // R10
endmodule

bind frac_mclk_div frac_mclk_div_chk #(.N_SRC(N_SRC), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .out_en    (out_en),
    .ratio_wr  (ratio_wr),
    .div_val   (div_val),
    .frac_val  (frac_val),
    .upd_busy  (upd_busy),
    .pulse_q   (pulse_q),
    .acc_q     (acc_q),
    .act_div   (act_div),
    .pend_div  (pend_div),
    .pend_frac (pend_frac)
);

// File: tb/test_frac_mclk_div.sv
`timescale 1ns/1ps
module test_frac_mclk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = '0;
    logic [1:0]  src_sel = '0;
    logic [11:0] div_val = '0;
    logic [7:0]  frac_val = '0;
    logic        ratio_wr = 1'b0;
    logic        out_en = 1'b0;
    logic        pad_in = 1'b0;
    logic        mclk_out;
    logic        upd_busy;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_acc = 0, m_adiv = 0, m_afrac = 0, m_pdiv = 0, m_pfrac = 0;
    int m_st = 0;
    bit m_pulse = 1'b0;

    always #5 clk = ~clk;

    frac_mclk_div i_frac_mclk_div (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_sel(src_sel),
        .div_val(div_val), .frac_val(frac_val), .ratio_wr(ratio_wr),
        .out_en(out_en), .pad_in(pad_in), .mclk_out(mclk_out), .upd_busy(upd_busy)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mclk();
        return out_en ? int'(m_pulse) : int'(pad_in);
    endfunction

    // advance the model by one edge using the inputs currently applied
    task automatic model_step();
        bit tick, bnd, apply, accept;
        int modv, sum, n_acc, n_st;
        tick   = src_en[src_sel];
        modv   = m_adiv + 1;
        sum    = m_acc + m_afrac + 1;
        bnd    = out_en && tick && (sum >= modv);
        apply  = (m_st == 1) && (bnd || !out_en);
        accept = (m_st == 0) && ratio_wr && (int'(frac_val) <= int'(div_val));
        if (!out_en) n_acc = 0;
        else if (bnd) n_acc = apply ? 0 : sum - modv;
        else if (tick) n_acc = sum;
        else n_acc = m_acc;
        n_st = m_st;
        if (m_st == 0 && accept) begin
            n_st = 1; m_pdiv = div_val; m_pfrac = frac_val;
        end else if (m_st == 1 && apply) begin
            n_st = 2; m_adiv = m_pdiv; m_afrac = m_pfrac;
        end else if (m_st == 2) begin
            n_st = 0;
        end
        m_acc = n_acc; m_st = n_st; m_pulse = bnd;
    endtask

    // one clock: model follows the edge, outputs checked at the falling edge
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(upd_busy == (m_st != 0), "R9 update flag", int'(upd_busy), int'(m_st != 0));
        check(int'(mclk_out) == exp_mclk(), "R3 output", int'(mclk_out), exp_mclk());
    endtask

    int cnt;
    int busy_cnt;

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        out_en = 1'b1;
        #1;
        // R1: reset state
        check(upd_busy == 1'b0, "R1 flag after reset", int'(upd_busy), 0);
        check(mclk_out == 1'b0, "R1 pulse after reset", int'(mclk_out), 0);
        rst_n = 1'b1;
        src_en = 4'hF; src_sel = 2'd0;
        cycle();
        check(mclk_out == 1'b1, "R1 unit ratio pulse", int'(mclk_out), 1);

        // R6: write 3/10
        ratio_wr = 1'b1; div_val = 12'd9; frac_val = 8'd2;
        cycle();
        check(upd_busy == 1'b1, "R6 flag after write", int'(upd_busy), 1);
        // R7: write while busy (4/4) must be ignored
        div_val = 12'd3; frac_val = 8'd3;
        cycle();
        check(upd_busy == 1'b1, "R9 flag in applied cycle", int'(upd_busy), 1);
        ratio_wr = 1'b0;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cycle();
            if (i == 0) check(upd_busy == 1'b0, "R9 flag cleared", int'(upd_busy), 0);
            cnt += int'(mclk_out);
        end
        check(cnt == 12, "R3 R7 pulses over 40 ticks", cnt, 12);

        // R5: bypass and hold
        out_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            pad_in = i[0];
            cycle();
            check(mclk_out == pad_in, "R5 bypass follows pad", int'(mclk_out), int'(pad_in));
        end
        pad_in = 1'b1; #1;
        check(mclk_out == 1'b1, "R5 bypass same cycle", int'(mclk_out), 1);
        pad_in = 1'b0;
        out_en = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            cycle();
            check(int'(mclk_out) == (i == 4 ? 1 : 0), "R5 restart from zero", int'(mclk_out), (i == 4 ? 1 : 0));
        end

        // R8 with divider off: applied next edge, flag high two cycles (R9)
        out_en = 1'b0; ratio_wr = 1'b1; div_val = 12'd4; frac_val = 8'd0;
        busy_cnt = 0;
        cycle();
        ratio_wr = 1'b0;
        busy_cnt += int'(upd_busy);
        for (int i = 0; i < 4; i++) begin
            cycle();
            busy_cnt += int'(upd_busy);
        end
        check(busy_cnt == 2, "R9 flag width when off", busy_cnt, 2);
        out_en = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            cycle();
            check(int'(mclk_out) == (i == 5 ? 1 : 0), "R8 new ratio 1/5", int'(mclk_out), (i == 5 ? 1 : 0));
        end

        // R8 handover while running: 1/2
        ratio_wr = 1'b1; div_val = 12'd1; frac_val = 8'd0;
        cycle();
        ratio_wr = 1'b0;
        for (int i = 0; i < 8; i++) cycle();

        // R2: select input 2
        src_sel = 2'd2; src_en = 4'b1011;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin cycle(); cnt += int'(mclk_out); end
        check(cnt == 0, "R2 unselected inputs ignored", cnt, 0);
        src_en = 4'b0100;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin cycle(); cnt += int'(mclk_out); end
        check(cnt == 6, "R2 selected input drives", cnt, 6);

        // R10: fraction above divide rejected
        src_en = 4'hF;
        ratio_wr = 1'b1; div_val = 12'd2; frac_val = 8'd9;
        cycle();
        ratio_wr = 1'b0;
        check(upd_busy == 1'b0, "R10 bad ratio ignored", int'(upd_busy), 0);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin cycle(); cnt += int'(mclk_out); end
        check(cnt == 4, "R10 ratio kept", cnt, 4);

        // full-scale ratio 256/4096
        ratio_wr = 1'b1; div_val = 12'hFFF; frac_val = 8'hFF;
        cycle();
        ratio_wr = 1'b0;
        for (int i = 0; i < 64; i++) cycle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            src_en   = 4'($urandom);
            src_sel  = 2'($urandom);
            out_en   = ($urandom % 8) != 0;
            pad_in   = 1'($urandom);
            ratio_wr = ($urandom % 6) == 0;
            if (($urandom % 16) == 0) div_val = 12'($urandom);
            else div_val = 12'($urandom % 16);
            if (($urandom % 8) == 0) frac_val = 8'($urandom);
            else frac_val = 8'($urandom % (int'(div_val) + 1));
            cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule